// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This controller connects a host that issues single read or write requests to an asynchronous dynamic RAM. The device has half as many address pins as the host address has bits. For each request the controller captures the full address and the write data. It then places the upper half of the address (the row) on the device pins and lowers the row strobe. After a programmable delay it places the lower half (the column) on the same pins and lowers the column strobe. The write-enable strobe is low during a write and stays high during a read. Read data is sampled in the last cycle of the column strobe and returned to the host with a single-cycle valid pulse.

The cells lose their charge within a retention window, so the controller contains a free-running refresh timer. At every timer expiry it raises a refresh request. Each refresh drives the next row from an internal row counter and lowers only the row strobe, with no column strobe and no data transfer. A pending refresh takes priority over new host requests. An access that has already started always runs to completion. A precharge gap of a set number of cycles separates every pair of row-strobe assertions.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, the row, column and write-enable strobes are high, `rsp_valid` is low and `req_ready` is high.
- R2: During an access, the row pins carry host address bits [ADDR_W-1:ADDR_W/2] when the row strobe falls. They carry bits [ADDR_W/2-1:0] when the column strobe falls, and hold that value while the column strobe is low.
- R3: The column strobe falls exactly T_RCD cycles after the row strobe falls and stays low for exactly T_CAS cycles. It is low only while the row strobe is low.
- R4: For a write, write-enable is low for the whole column-strobe pulse and `dram_dq_out` equals the host write data. For a read, write-enable stays high.
- R5: A read accepted at clock edge k gives a single-cycle `rsp_valid` pulse that is visible after edge k+T_RCD+T_CAS. The pulse carries the data the device drove in the last column-strobe cycle. Writes give no response.
- R6: A refresh holds the row strobe low for T_RCD+T_CAS cycles, with the column strobe and write-enable high throughout.
- R7: Refreshes drive rows 0,1,2,… in order and wrap from 2^(ADDR_W/2)-1 back to 0.
- R8: A refresh request is raised every REF_PERIOD cycles. Consecutive refresh starts are never more than REF_PERIOD+T_RCD+T_CAS+T_RP+2 cycles apart, even under continuous host traffic.
- R9: A pending refresh is served before any new host request, and an access in progress is never cut short.
- R10: Between two row-strobe assertions the row strobe is high for at least T_RP cycles.
- R11: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low whenever the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full host address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data to the device |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
A read response is due exactly T_RCD+T_CAS+1 cycle counts after the falling clock edge on which the driver sees `req_ready`. The driver stores that due count with the expected data, and the monitor rejects any pulse that arrives early or late. The behavioural device model measures strobe spacing in clock counts on falling edges. The column strobe must follow the row strobe by T_RCD and last T_CAS. A refresh must last T_RCD+T_CAS. The precharge gap must be at least T_RP, and the gap between refresh starts is compared with the R8 bound.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 2,
  parameter int REF_PERIOD = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int HALF  = ADDR_W / 2;
  localparam int RW    = $clog2(REF_PERIOD);
  localparam int T_REF = T_RCD + T_CAS;
  localparam int CW    = $clog2(T_RCD + T_CAS + T_RP + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} st_t;

  st_t               st;
  logic [CW-1:0]     tmr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [HALF-1:0]   ref_row;
  logic [RW-1:0]     ref_cnt;
  logic              ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      ref_row   <= '0;
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (ref_pend) begin
            st       <= S_REF;
            tmr      <= CW'(T_REF - 1);
            ref_pend <= 1'b0;
          end else if (req_valid) begin
            st      <= S_ROW;
            tmr     <= CW'(T_RCD - 1);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            we_q    <= req_we;
          end
        S_ROW:
          if (tmr == '0) begin
            st  <= S_COL;
            tmr <= CW'(T_CAS - 1);
          end else tmr <= tmr - 1'b1;
        S_COL:
          if (tmr == '0) begin
            st  <= S_PRE;
            tmr <= CW'(T_RP - 1);
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end else tmr <= tmr - 1'b1;
        S_REF:
          if (tmr == '0) begin
            st      <= S_PRE;
            tmr     <= CW'(T_RP - 1);
            ref_row <= ref_row + 1'b1;
          end else tmr <= tmr - 1'b1;
        S_PRE:
          if (tmr == '0) st <= S_IDLE;
          else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (ref_cnt == RW'(REF_PERIOD - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign dram_ras_n  = !(st == S_ROW || st == S_COL || st == S_REF);
  assign dram_cas_n  = (st != S_COL);
  assign dram_we_n   = !(st == S_COL && we_q);
  assign dram_dq_out = wdata_q;
  assign dram_addr   = (st == S_REF) ? ref_row :
                       (st == S_COL) ? addr_q[HALF-1:0] : addr_q[ADDR_W-1:HALF];

  logic [CW-1:0] ras_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) ras_hi <= CW'(T_RP);
    else if (!dram_ras_n) ras_hi <= '0;
    else if (ras_hi < CW'(T_RP)) ras_hi <= ras_hi + 1'b1;
  end

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_hi >= CW'(T_RP)); // R10
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> !dram_ras_n && $past(!dram_ras_n)); // R3
  AST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr)); // R2
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REF) |-> dram_cas_n && dram_we_n); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_READY_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_ras_n && dram_cas_n); // R11
  AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_REF && st == S_PRE) |-> ref_row == $past(ref_row) + 1'b1); // R7
endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
  localparam int ADDR_W = 8, DATA_W = 8, HALF = ADDR_W / 2;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, REF_PERIOD = 40;
  localparam int LAT = T_RCD + T_CAS + 1;
  localparam int BOUND = REF_PERIOD + T_RCD + T_CAS + T_RP + 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n;
  logic [DATA_W-1:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [HALF-1:0] dram_addr;

  dram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
              .T_RP(T_RP), .REF_PERIOD(REF_PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in));

  always #4 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [DATA_W-1:0] q_data[$];
  int q_due[$];
  logic [DATA_W-1:0] shadow [2**ADDR_W];
  logic [ADDR_W-1:0] exp_addr = '0;
  logic [DATA_W-1:0] exp_data = '0;
  bit exp_we = 0;

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (q_data.size() == 0) chk(0, "R5", "unexpected response", 1, 0);
      else begin
        chk(rsp_rdata == q_data[0], "R5", "read data", rsp_rdata, q_data[0]);
        chk(cyc == q_due[0], "R5", "response cycle", cyc, q_due[0]);
        void'(q_data.pop_front()); void'(q_due.pop_front());
      end
    end else if (q_due.size() != 0 && cyc > q_due[0]) begin
      chk(0, "R5", "missing response", cyc, q_due[0]);
      void'(q_data.pop_front()); void'(q_due.pop_front());
    end
  end

  task automatic access(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_addr = a; exp_we = we; exp_data = d;
    if (we) shadow[a] = d;
    else begin q_data.push_back(shadow[a]); q_due.push_back(cyc + LAT); end
    @(posedge clk); #1 req_valid = 0;
  endtask

  // behavioural device model
  logic [DATA_W-1:0] mem [2**ADDR_W];
  logic [HALF-1:0] m_row = '0, m_col = '0;
  logic pr_ras = 1, pr_cas = 1, pr_we = 1;
  int ras_fall = 0, cas_fall = 0, hi_cnt = 100, last_ref = 0, nref = 0;
  bit cas_seen = 0, we_seen = 0;
  logic [HALF-1:0] exp_ref = '0;

  assign dram_dq_in = (!dram_cas_n && dram_we_n) ? mem[{m_row, m_col}] : '0;

  always @(negedge clk) if (rst_n) begin
    if (pr_ras && !dram_ras_n) begin
      chk(hi_cnt >= T_RP, "R10", "precharge gap", hi_cnt, T_RP);
      m_row = dram_addr; ras_fall = cyc; cas_seen = 0; we_seen = 0;
    end
    if (!dram_ras_n && !dram_we_n) we_seen = 1;
    if (!dram_ras_n) chk(!req_ready, "R11", "ready while busy", req_ready, 0);
    if (pr_cas && !dram_cas_n) begin
      chk(!dram_ras_n, "R3", "cas without ras", dram_ras_n, 0);
      chk(cyc - ras_fall == T_RCD, "R3", "ras-to-cas", cyc - ras_fall, T_RCD);
      m_col = dram_addr; cas_fall = cyc; cas_seen = 1;
      chk({m_row, m_col} == exp_addr, "R2", "row/col address", {m_row, m_col}, exp_addr);
      chk(!dram_we_n == exp_we, "R4", "write enable", !dram_we_n, exp_we);
      if (!dram_we_n) begin
        chk(dram_dq_out == exp_data, "R4", "write data", dram_dq_out, exp_data);
        mem[{m_row, m_col}] = dram_dq_out;
      end
    end else if (!dram_cas_n) begin
      chk(dram_we_n == pr_we, "R4", "we steady", dram_we_n, pr_we);
      chk(dram_addr == m_col, "R2", "column held", dram_addr, m_col);
    end
    if (!pr_cas && dram_cas_n)
      chk(cyc - cas_fall == T_CAS, "R3", "cas width", cyc - cas_fall, T_CAS);
    if (!pr_ras && dram_ras_n && !cas_seen) begin
      chk(cyc - ras_fall == T_RCD + T_CAS, "R6", "refresh width", cyc - ras_fall, T_RCD + T_CAS);
      chk(!we_seen, "R6", "we during refresh", we_seen, 0);
      chk(m_row == exp_ref, "R7", "refresh row", m_row, exp_ref);
      chk(ras_fall - last_ref <= BOUND, "R8", "refresh interval", ras_fall - last_ref, BOUND);
      exp_ref = exp_ref + 1'b1; last_ref = ras_fall; nref++;
    end
    if (dram_ras_n) hi_cnt++; else hi_cnt = 0;
    pr_ras = dram_ras_n; pr_cas = dram_cas_n; pr_we = dram_we_n;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc == 60000);
    chk(0, "WATCHDOG", "timeout", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2**ADDR_W; i++) begin shadow[i] = '0; mem[i] = '0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    last_ref = cyc;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(req_ready == 1, "R1", "ready", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    // corner patterns
    access(1, 8'h00, 8'h3C);
    access(1, 8'hFF, 8'hC3);
    access(1, 8'hA5, 8'h5A);
    access(1, 8'h5A, 8'hA5);
    access(0, 8'h00, 8'h00);
    access(0, 8'hFF, 8'h00);
    access(0, 8'hA5, 8'h00);
    access(0, 8'h5A, 8'h00);
    access(0, 8'h11, 8'h00);
    // back-to-back stream across many refresh periods (R9)
    for (int i = 0; i < 80; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(i * 37 + 3);
      access(i[0] == 1'b0, a, DATA_W'(i * 13 + 7));
      if (i[0]) access(0, ADDR_W'((i - 1) * 37 + 3), 8'h00);
    end
    // idle to watch refresh wrap (R7, R8)
    repeat (20 * REF_PERIOD) @(negedge clk);
    chk(nref > 2**HALF, "R7", "refresh count past wrap", nref, 2**HALF + 1);
    chk(q_data.size() == 0, "R5", "responses outstanding", q_data.size(), 0);
    finish_run();
  end
endmodule